// File: doc/BRIEF.md
# JTAG Master Shift Engine

This block is a JTAG master. It generates TCK from the system clock, drives TMS and TDI, and samples TDO from a single target test access port. Each command names the scan: an instruction-register shift, a data-register shift, a TAP reset, or an automatic ID-code read. For a shift, the command also gives the word to send, a bit count from 1 to 32 and the bit order. The captured TDO bits come back as a result word.

Two per-command flags let software split one long scan across several commands. The first flag keeps TMS low on the last bit, so the target stays in its Shift state. The second flag stops the engine after it leaves Shift, so it does not walk back to Run-Test/Idle. The engine remembers where it left the target. The next command then starts from that point, or it first finishes the walk back to Run-Test/Idle. The ID-code read loads the IDCODE instruction, with a length taken from a 3-bit core-generation input, and then reads a 32-bit data register.

Top module: `jtag_shift_master`

## Requirements
- R1: While reset is held and after reset is released, tck, busy, done and err are low and result is zero.
- R2: With order select low, data bit 0 is the first to appear on tdi during the shift. Bit i of result holds the TDO value captured at the i-th data rising edge. Outside the data bits, tdi is low.
- R3: With order select high, bit nbits-1 of the word is the first to appear on tdi. The first captured TDO bit lands in result bit nbits-1. Result bits at nbits and above are zero.
- R4: With the no-end flag clear, TMS is high on the final data bit. With the flag set, TMS stays low on every data bit and the target remains in Shift. A following shift command then sends data bits immediately, with no navigation.
- R5: After the exit on the final bit, the engine sends TMS 1 then 0, which ends in Run-Test/Idle. It skips this when the no-return flag is set. In that case the next command first sends 1,0 and then its own navigation.
- R6: Starting from Run-Test/Idle, an instruction shift (op 0) is preceded by TMS 1,1,0,0. A data shift (op 1) is preceded by TMS 1,0,0.
- R7: TCK has a period of 2*HALF system clocks. TMS and TDI change only while TCK is low. TDO is sampled at the TCK rising edge.
- R8: A reset command (op 2) sends TMS high on five TCK cycles and then low on one cycle. This leaves the target in Run-Test/Idle.
- R9: An ID-code read (op 3) shifts an instruction LSB-first and returns to idle. The instruction is 5'h1E over 5 bits when core_gen is 1, or 7'h7E over 7 bits when core_gen is 2. The engine then sends TMS 1,0,0 and shifts 32 zero bits LSB-first, exits and returns to idle. The 32 captured bits are the result.
- R10: A shift with nbits of 0 or above 32, or an ID-code read with core_gen other than 1 or 2, returns done and err together in the cycle after acceptance, with no TCK edges.
- R11: A command is accepted only while busy is low. cmd_valid is ignored while busy is high. done is a single-cycle pulse, and result is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 instruction shift, 1 data shift, 2 TAP reset, 3 ID-code read |
| cmd_word | input | 32 | Bits to send |
| cmd_nbits | input | 6 | Number of bits to shift, 1 to 32 |
| cmd_msb_first | input | 1 | Order select, high for MSB first |
| cmd_no_end | input | 1 | Keep the target in Shift after the last bit |
| cmd_no_idle | input | 1 | Do not walk back to Run-Test/Idle after the exit |
| core_gen | input | 3 | Core-generation code selecting the instruction length for op 3 |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Command rejected, valid with done |
| result | output | 32 | Captured TDO bits |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the target |
| tdo | input | 1 | Test data from the target |

## Verification
The assertions take two things for granted. First, command inputs only matter in the single cycle in which cmd_valid is seen with busy low. Second, tdo settles within half a TCK period after the falling edge. The bench drives each command for exactly one clock. Its target model updates tdo only on TCK falling edges, and it follows the TAP state from the TMS value seen at each rising edge. This lets the end state of every scan be checked against the standard state graph.

// File: rtl/jtag_shift_master.sv
module jtag_shift_master #(
  parameter int          HALF = 2,
  parameter logic [4:0]  IDC5 = 5'h1E,
  parameter logic [6:0]  IDC7 = 7'h7E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [31:0] cmd_word,
  input  logic [5:0]  cmd_nbits,
  input  logic        cmd_msb_first,
  input  logic        cmd_no_end,
  input  logic        cmd_no_idle,
  input  logic [2:0]  core_gen,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [31:0] result,
  output logic        tck,
  output logic        tms,
  output logic        tdi,
  input  logic        tdo
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [1:0] OP_IR = 2'd0, OP_DR = 2'd1, OP_RST = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_SHIFT, ST_POST} st_t;
  typedef enum logic [1:0] {P_IDLE, P_SHIFT, P_EXIT} pos_t;

  st_t         st;
  pos_t        pos;
  logic        ph, msb, no_end, no_idle, is_rst, chain;
  logic [CW-1:0] cnt;
  logic [5:0]  nav_v;
  logic [2:0]  nav_n;
  logic [31:0] word, cap;
  logic [5:0]  n, nm1;
  logic [4:0]  k, idx;
  logic        tick, last, fin, bad_n, cg_ok;

  function automatic logic [8:0] path(input logic ir, input pos_t p);
    case (p)
      P_IDLE:  path = ir ? {3'd4, 6'b000011} : {3'd3, 6'b000001};
      P_EXIT:  path = ir ? {3'd6, 6'b001101} : {3'd5, 6'b000101};
      default: path = 9'd0;
    endcase
  endfunction

  assign tick  = (cnt == CW'(HALF - 1));
  assign nm1   = n - 6'd1;
  assign idx   = msb ? 5'(nm1 - {1'b0, k}) : k;
  assign last  = ({1'b0, k} == nm1);
  assign bad_n = (cmd_nbits == 6'd0) || (cmd_nbits > 6'd32);
  assign cg_ok = (core_gen == 3'd1) || (core_gen == 3'd2);
  assign fin   = (st == ST_PRE && nav_n <= 3'd1 && is_rst) ||
                 (st == ST_SHIFT && last && (no_end || no_idle)) ||
                 (st == ST_POST && nav_n <= 3'd1);

  assign busy = (st != ST_IDLE);
  assign tck  = ph;
  assign tms  = (st == ST_PRE || st == ST_POST) ? nav_v[0] :
                (st == ST_SHIFT) ? (last && !no_end) : 1'b0;
  assign tdi  = (st == ST_SHIFT) ? word[idx] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  pos <= P_IDLE;  ph <= 1'b0;  cnt <= '0;
      msb <= 1'b0;  no_end <= 1'b0;  no_idle <= 1'b0;  is_rst <= 1'b0;  chain <= 1'b0;
      nav_v <= '0;  nav_n <= '0;  word <= '0;  cap <= '0;  n <= '0;  k <= '0;
      done <= 1'b0;  err <= 1'b0;  result <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (st == ST_IDLE) begin
        if (cmd_valid) begin
          cap <= '0;  ph <= 1'b0;  cnt <= '0;  k <= '0;  is_rst <= 1'b0;  chain <= 1'b0;
          case (cmd_op)
            OP_RST: begin
              is_rst <= 1'b1;
              nav_v  <= 6'b011111;
              nav_n  <= 3'd6;
              st     <= ST_PRE;
            end
            OP_IR, OP_DR: begin
              if (bad_n) begin
                done <= 1'b1;
                err  <= 1'b1;
              end else begin
                word    <= cmd_word;
                n       <= cmd_nbits;
                msb     <= cmd_msb_first;
                no_end  <= cmd_no_end;
                no_idle <= cmd_no_idle;
                {nav_n, nav_v} <= path(cmd_op == OP_IR, pos);
                st      <= (pos == P_SHIFT) ? ST_SHIFT : ST_PRE;
              end
            end
            default: begin
              if (!cg_ok) begin
                done <= 1'b1;
                err  <= 1'b1;
              end else begin
                chain   <= 1'b1;
                word    <= (core_gen == 3'd1) ? 32'(IDC5) : 32'(IDC7);
                n       <= (core_gen == 3'd1) ? 6'd5 : 6'd7;
                msb     <= 1'b0;
                no_end  <= 1'b0;
                no_idle <= 1'b0;
                {nav_n, nav_v} <= path(1'b1, pos);
                st      <= (pos == P_SHIFT) ? ST_SHIFT : ST_PRE;
              end
            end
          endcase
        end
      end else if (!tick) begin
        cnt <= cnt + CW'(1);
      end else begin
        cnt <= '0;
        if (!ph) begin
          ph <= 1'b1;
          if (st == ST_SHIFT) cap[idx] <= tdo;
        end else begin
          ph <= 1'b0;
          if (fin) begin
            if (chain) begin
              chain   <= 1'b0;
              word    <= '0;
              n       <= 6'd32;
              k       <= '0;
              msb     <= 1'b0;
              cap     <= '0;
              nav_v   <= 6'b000001;
              nav_n   <= 3'd3;
              pos     <= P_IDLE;
              st      <= ST_PRE;
            end else begin
              st     <= ST_IDLE;
              done   <= 1'b1;
              result <= cap;
              pos    <= is_rst ? P_IDLE : no_end ? P_SHIFT : no_idle ? P_EXIT : P_IDLE;
            end
          end else begin
            case (st)
              ST_PRE: begin
                if (nav_n > 3'd1) begin
                  nav_v <= nav_v >> 1;
                  nav_n <= nav_n - 3'd1;
                end else begin
                  st <= ST_SHIFT;
                  k  <= '0;
                end
              end
              ST_SHIFT: begin
                if (last) begin
                  st    <= ST_POST;
                  nav_v <= 6'b000001;
                  nav_n <= 3'd2;
                end else begin
                  k <= k + 5'd1;
                end
              end
              ST_POST: begin
                nav_v <= nav_v >> 1;
                nav_n <= nav_n - 3'd1;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/jtag_shift_master_chk.sv
module jtag_shift_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic err,
  input logic tck,
  input logic tms,
  input logic tdi
);
  // R7
  pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> ($stable(tms) && $stable(tdi)));

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R11
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  // R11
  done_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R1
  tck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);
endmodule

bind jtag_shift_master jtag_shift_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .err(err), .tck(tck), .tms(tms), .tdi(tdi)
);

// File: tb/test_jtag_shift_master.sv
module test_jtag_shift_master;
  localparam int HALF = 2;
  localparam int TLR = 0, RTI = 1, SELDR = 2, CAPDR = 3, SHDR = 4, EX1DR = 5, PADR = 6,
                 EX2DR = 7, UPDR = 8, SELIR = 9, CAPIR = 10, SHIR = 11, EX1IR = 12,
                 PAIR = 13, EX2IR = 14, UPIR = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [31:0] cmd_word = '0;
  logic [5:0] cmd_nbits = '0;
  logic cmd_msb_first = 1'b0, cmd_no_end = 1'b0, cmd_no_idle = 1'b0;
  logic [2:0] core_gen = 3'd1;
  logic busy, done, err, tck, tms, tdi;
  logic [31:0] result;
  logic tdo = 1'b0;

  int nchk = 0, nfail = 0;
  int nrise = 0, tap = TLR, edge_bad = 0;
  logic [63:0] rec_tms = '0, rec_tdi = '0, tdo_pat = 64'hC3A5_96F0_1E2D_7B48;
  time rise_t[64];
  logic [31:0] got_res;
  logic got_err;
  logic prev_tck = 1'b0, prev_tms = 1'b0, prev_tdi = 1'b0;

  always #10 clk = ~clk;

  jtag_shift_master #(.HALF(HALF)) i_jtag_shift_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_word(cmd_word),
    .cmd_nbits(cmd_nbits), .cmd_msb_first(cmd_msb_first), .cmd_no_end(cmd_no_end),
    .cmd_no_idle(cmd_no_idle), .core_gen(core_gen), .busy(busy), .done(done), .err(err),
    .result(result), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  function automatic int tap_next(int s, logic m);
    case (s)
      TLR:   return m ? TLR   : RTI;
      RTI:   return m ? SELDR : RTI;
      SELDR: return m ? SELIR : CAPDR;
      CAPDR: return m ? EX1DR : SHDR;
      SHDR:  return m ? EX1DR : SHDR;
      EX1DR: return m ? UPDR  : PADR;
      PADR:  return m ? EX2DR : PADR;
      EX2DR: return m ? UPDR  : SHDR;
      UPDR:  return m ? SELDR : RTI;
      SELIR: return m ? TLR   : CAPIR;
      CAPIR: return m ? EX1IR : SHIR;
      SHIR:  return m ? EX1IR : SHIR;
      EX1IR: return m ? UPIR  : PAIR;
      PAIR:  return m ? EX2IR : PAIR;
      EX2IR: return m ? UPIR  : SHIR;
      default: return m ? SELDR : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    if (nrise < 64) begin
      rec_tms[nrise] = tms;
      rec_tdi[nrise] = tdi;
      rise_t[nrise]  = $time;
    end
    nrise = nrise + 1;
    tap = tap_next(tap, tms);
  end

  always @(negedge tck) if (nrise < 64) tdo = tdo_pat[nrise];

  always @(negedge clk) begin
    if (rst_n && tck && prev_tck && (tms !== prev_tms || tdi !== prev_tdi)) edge_bad++;
    prev_tck = tck; prev_tms = tms; prev_tdi = tdi;
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(logic [1:0] op, logic [31:0] w, logic [5:0] nb, logic m, logic ne, logic ni);
    nrise = 0; rec_tms = '0; rec_tdi = '0; tdo = tdo_pat[0];
    @(negedge clk);
    cmd_op = op; cmd_word = w; cmd_nbits = nb; cmd_msb_first = m;
    cmd_no_end = ne; cmd_no_idle = ni; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    got_res = result; got_err = err;
  endtask

  task automatic exp_shift(int st0, int n, logic m, logic [31:0] w,
                           inout logic [63:0] tdi_e, output logic [31:0] res_e);
    res_e = '0;
    for (int k = 0; k < n; k++) begin
      int ix = m ? n - 1 - k : k;
      tdi_e[st0 + k] = w[ix];
      res_e[ix] = tdo_pat[st0 + k];
    end
  endtask

  task automatic t_reset_state();
    chk("R1", "tck in reset", {63'd0, tck}, 64'd0);
    chk("R1", "busy/done/err in reset", {61'd0, busy, done, err}, 64'd0);
    chk("R1", "result in reset", {32'd0, result}, 64'd0);
  endtask

  task automatic t_tap_reset();
    run(2'd2, '0, 6'd0, 1'b0, 1'b0, 1'b0);
    chk("R8", "reset edge count", nrise, 6);
    chk("R8", "reset tms", rec_tms & 64'h3F, 64'h1F);
    chk("R8", "tap after reset", tap, RTI);
  endtask

  task automatic t_ir_lsb();
    logic [63:0] te = '0; logic [31:0] re;
    tdo_pat = 64'h0000_0000_0000_0150;
    exp_shift(4, 5, 1'b0, 32'h15, te, re);
    run(2'd0, 32'h15, 6'd5, 1'b0, 1'b0, 1'b0);
    chk("R6", "ir edge count", nrise, 11);
    chk("R6", "ir nav and exit tms", rec_tms, 64'h303);
    chk("R2", "ir lsb tdi", rec_tdi, te);
    chk("R2", "ir lsb result", got_res, re);
    chk("R5", "tap after ir", tap, RTI);
  endtask

  task automatic t_dr_msb();
    logic [63:0] te = '0; logic [31:0] re;
    tdo_pat = 64'h0000_0000_0000_9A38;
    exp_shift(3, 12, 1'b1, 32'hFFFF_F5C3, te, re);
    run(2'd1, 32'hFFFF_F5C3, 6'd12, 1'b1, 1'b0, 1'b0);
    chk("R6", "dr edge count", nrise, 17);
    chk("R6", "dr nav tms", rec_tms, 64'hC001);
    chk("R3", "dr msb tdi", rec_tdi, te);
    chk("R3", "dr msb result", got_res, re);
    chk("R3", "dr msb upper bits zero", got_res & 32'hFFFF_F000, 0);
  endtask

  task automatic t_dr_32();
    logic [63:0] te = '0; logic [31:0] re;
    tdo_pat = 64'h5A3C_E1F0_7B2D_9468;
    exp_shift(3, 32, 1'b0, 32'hDEAD_BEEF, te, re);
    run(2'd1, 32'hDEAD_BEEF, 6'd32, 1'b0, 1'b0, 1'b0);
    chk("R2", "dr32 edge count", nrise, 37);
    chk("R2", "dr32 tdi", rec_tdi, te);
    chk("R2", "dr32 result", got_res, re);
    chk("R4", "dr32 tms", rec_tms, (64'd1 << 34) | (64'd1 << 35) | 64'd1);
  endtask

  task automatic t_noend();
    logic [63:0] te = '0; logic [31:0] re;
    tdo_pat = 64'h0000_0000_0000_06C5;
    run(2'd1, 32'h0000_00A7, 6'd8, 1'b0, 1'b1, 1'b0);
    chk("R4", "noend edge count", nrise, 11);
    chk("R4", "noend tms low in shift", rec_tms, 64'h1);
    chk("R4", "tap stays in shift", tap, SHDR);
    exp_shift(0, 8, 1'b0, 32'h0000_003C, te, re);
    run(2'd1, 32'h0000_003C, 6'd8, 1'b0, 1'b0, 1'b0);
    chk("R4", "continue edge count", nrise, 10);
    chk("R4", "continue tms", rec_tms, 64'h180);
    chk("R4", "continue tdi", rec_tdi, te);
    chk("R4", "continue result", got_res, re);
    chk("R4", "tap after continue", tap, RTI);
  endtask

  task automatic t_noidle();
    run(2'd0, 32'h0000_0055, 6'd7, 1'b0, 1'b0, 1'b1);
    chk("R5", "noidle edge count", nrise, 11);
    chk("R5", "noidle tms", rec_tms, 64'h403);
    chk("R5", "tap held in exit", tap, EX1IR);
    run(2'd1, 32'h0000_0009, 6'd4, 1'b0, 1'b0, 1'b0);
    chk("R5", "resume edge count", nrise, 11);
    chk("R5", "resume tms", rec_tms, 64'h305);
    chk("R5", "tap after resume", tap, RTI);
  endtask

  task automatic t_idcode(logic [2:0] cg);
    logic [63:0] te = '0; logic [31:0] re, junk;
    int ir_n = (cg == 3'd1) ? 5 : 7;
    int ds = 4 + ir_n + 2 + 3;
    tdo_pat = 64'h1B4E_7A39_C2D5_60F3;
    core_gen = cg;
    exp_shift(4, ir_n, 1'b0, (cg == 3'd1) ? 32'h1E : 32'h7E, te, junk);
    exp_shift(ds, 32, 1'b0, 32'h0, te, re);
    run(2'd3, '0, 6'd0, 1'b0, 1'b0, 1'b0);
    chk("R9", "idcode edge count", nrise, ds + 34);
    chk("R9", "idcode tms", rec_tms,
        (cg == 3'd1) ? 64'h0000_6000_0000_0B03 : 64'h0001_8000_0000_2C03);
    chk("R9", "idcode tdi", rec_tdi, te);
    chk("R9", "idcode result", got_res, re);
    chk("R9", "idcode err", got_err, 0);
    chk("R9", "tap after idcode", tap, RTI);
  endtask

  task automatic t_errors();
    run(2'd1, 32'h1, 6'd0, 1'b0, 1'b0, 1'b0);
    chk("R10", "zero length err", got_err, 1);
    chk("R10", "zero length no tck", nrise, 0);
    run(2'd0, 32'h1, 6'd33, 1'b0, 1'b0, 1'b0);
    chk("R10", "long length err", got_err, 1);
    chk("R10", "long length no tck", nrise, 0);
    core_gen = 3'd3;
    run(2'd3, '0, 6'd0, 1'b0, 1'b0, 1'b0);
    chk("R10", "bad core_gen err", got_err, 1);
    chk("R10", "bad core_gen no tck", nrise, 0);
    chk("R10", "tap untouched", tap, RTI);
  endtask

  task automatic t_timing();
    edge_bad = 0;
    run(2'd1, 32'h0000_0F0F, 6'd16, 1'b0, 1'b0, 1'b0);
    chk("R7", "tck period ns", 64'(rise_t[5] - rise_t[4]), 64'(2 * HALF * 20));
    chk("R7", "pins change only while tck low", edge_bad, 0);
  endtask

  task automatic t_busy();
    logic [63:0] te = '0; logic [31:0] re;
    tdo_pat = 64'h0000_0000_3E91_C7A2;
    exp_shift(3, 16, 1'b0, 32'h0000_B7E1, te, re);
    nrise = 0; rec_tms = '0; rec_tdi = '0; tdo = tdo_pat[0];
    @(negedge clk);
    cmd_op = 2'd1; cmd_word = 32'h0000_B7E1; cmd_nbits = 6'd16; cmd_msb_first = 1'b0;
    cmd_no_end = 1'b0; cmd_no_idle = 1'b0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk("R11", "busy during command", busy, 1);
    cmd_op = 2'd2; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    got_res = result;
    @(negedge clk);
    chk("R11", "done single pulse", done, 0);
    chk("R11", "ignored command edge count", nrise, 21);
    chk("R11", "result with ignored command", got_res, re);
    chk("R11", "tdi with ignored command", rec_tdi, te);
    chk("R11", "tap after ignored command", tap, RTI);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_tap_reset();
    t_ir_lsb();
    t_dr_msb();
    t_dr_32();
    t_noend();
    t_noidle();
    t_idcode(3'd1);
    t_idcode(3'd2);
    t_errors();
    t_timing();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule